// File: doc/BRIEF.md
# PLL Lock-Loss Indicator with Stretched Output

This block watches the phase-error pulses of a phase-frequency detector and drives an active-low indicator that says the loop has lost lock. The up and down error pulses are merged into one error level, and the width of each error pulse is counted in reference-clock cycles. A two-bit mode input picks the behaviour. The indicator can be held inactive. It can follow the merged error level directly. It can also compare each pulse against a narrow or a wide width limit.

In the two comparing modes, a pulse that runs past the chosen limit pulls the indicator low. The indicator then stays low until the second tick of a free-running one-millisecond tick input after the last offending pulse. This stretches every lock-loss event to between one and two milliseconds, so slow logic can see it. A new offending pulse during the stretch starts the stretch over. The inputs are assumed synchronous to the reference clock.

Top module: `pll_unlock_watch`

## Requirements
- R1: After reset the indicator `unlock_n` is high (inactive) in every mode except pass-through with an active error.
- R2: With `mode` = 2'b00 (stopped), `unlock_n` stays high whatever the error inputs do.
- R3: With `mode` = 2'b01 (pass-through), `unlock_n` equals NOT(`up_err` OR `dn_err`) in the same cycle.
- R4: With `mode` = 2'b10 (narrow limit), an error pulse longer than THR_NARROW consecutive cycles drives `unlock_n` low one cycle after its (THR_NARROW+1)-th high cycle. A pulse of THR_NARROW cycles or fewer leaves it high.
- R5: With `mode` = 2'b11 (wide limit), the same rule applies with THR_WIDE in place of THR_NARROW.
- R6: Error width counts consecutive cycles in which either `up_err` or `dn_err` is high, so a pulse on either input alone is judged the same way.
- R7: Once lock loss is flagged in a comparing mode, `unlock_n` stays low until the cycle after the EXT_TICKS-th (default 2) `ms_tick` pulse that follows the last violating cycle. It then returns high.
- R8: A new violation while the indicator is stretched restarts the tick count from zero.
- R9: Leaving the comparing modes (mode bit 1 low) clears any pending stretch, so a later return to a comparing mode starts with `unlock_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock used to measure error width |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_err | input | 1 | Up phase-error pulse from the detector |
| dn_err | input | 1 | Down phase-error pulse from the detector |
| ms_tick | input | 1 | One-cycle pulse every millisecond, free running |
| mode | input | 2 | 00 stop, 01 pass-through, 10 narrow limit, 11 wide limit |
| unlock_n | output | 1 | Active-low lock-loss indicator (high = open/inactive) |

## Verification
The bench sweeps pulse widths from 1 to 12 cycles on each error input under both limits. The result must flip exactly at limit+1; an off-by-one comparator would flag a pulse of exactly the limit or miss one cycle beyond it. The stretch is checked tick by tick. A timer that freed on the first tick, or that ignored a new violation mid-stretch, would raise the indicator one tick early. Mode changes are checked too: a stopped mode that leaked errors, a pass-through with a register delay, or a stretch surviving a trip out of the comparing modes would each show a wrong level at the sampled cycle.

// File: rtl/ulw_pkg.sv
package ulw_pkg;
  typedef enum logic [1:0] {
    UL_STOP   = 2'b00,
    UL_PASS   = 2'b01,
    UL_NARROW = 2'b10,
    UL_WIDE   = 2'b11
  } ul_mode_e;
endpackage

// File: rtl/ulw_width_meter.sv
module ulw_width_meter #(
  parameter int THR_NARROW = 4,
  parameter int THR_WIDE   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic err,
  input  logic wide_sel,
  output logic viol
);
  localparam int CW = $clog2(THR_WIDE + 2);
  localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] LIM_N = CW'(THR_NARROW);
  localparam logic [CW-1:0] LIM_W = CW'(THR_WIDE);

  logic [CW-1:0] run_q, run_d, lim;
  logic          run_ce;

  always_comb begin
    lim = wide_sel ? LIM_W : LIM_N;
    // current cycle is high cycle number run_q+1
    viol = en && err && (run_q >= lim);
  end

  always_comb begin
    run_d  = run_q;
    run_ce = 1'b0;
    if (!en || !err) begin
      run_ce = (run_q != '0);
      run_d  = '0;
    end else if (run_q != RUN_MAX) begin
      run_ce = 1'b1;
      run_d  = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_ce) run_q <= run_d;
  end
endmodule

// File: rtl/ulw_ext_timer.sv
module ulw_ext_timer #(
  parameter int EXT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic viol,
  input  logic tick,
  output logic hold
);
  localparam int TW = $clog2(EXT_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(EXT_TICKS - 1);

  logic          hold_q, hold_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          ce;

  always_comb begin
    hold_d = hold_q;
    tcnt_d = tcnt_q;
    ce     = 1'b0;
    if (!en) begin
      ce     = hold_q || (tcnt_q != '0);
      hold_d = 1'b0;
      tcnt_d = '0;
    end else if (viol) begin
      ce     = 1'b1;
      hold_d = 1'b1;
      tcnt_d = '0;
    end else if (hold_q && tick) begin
      ce = 1'b1;
      if (tcnt_q == LAST) begin
        hold_d = 1'b0;
        tcnt_d = '0;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      tcnt_q <= '0;
    end else if (ce) begin
      hold_q <= hold_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign hold = hold_q;
endmodule

// File: rtl/pll_unlock_watch.sv
module pll_unlock_watch #(
  parameter int THR_NARROW = 4,
  parameter int THR_WIDE   = 8,
  parameter int EXT_TICKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_err,
  input  logic       dn_err,
  input  logic       ms_tick,
  input  logic [1:0] mode,
  output logic       unlock_n
);
  import ulw_pkg::*;

  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       err, det_en, viol, hold;
  ul_mode_e   md;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign err    = up_err | dn_err;
  assign md     = ul_mode_e'(mode);
  assign det_en = (md == UL_NARROW) || (md == UL_WIDE);

  ulw_width_meter #(.THR_NARROW(THR_NARROW), .THR_WIDE(THR_WIDE)) u_meter (
    .clk(clk), .rst_n(rst_int_n), .en(det_en), .err(err),
    .wide_sel(md == UL_WIDE), .viol(viol)
  );

  ulw_ext_timer #(.EXT_TICKS(EXT_TICKS)) u_ext (
    .clk(clk), .rst_n(rst_int_n), .en(det_en), .viol(viol),
    .tick(ms_tick), .hold(hold)
  );

  always_comb begin
    unique case (md)
      UL_STOP:  unlock_n = 1'b1;
      UL_PASS:  unlock_n = ~err;
      default:  unlock_n = ~hold;
    endcase
  end
endmodule

// File: rtl/ulw_checker.sv
module ulw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       up_err,
  input logic       dn_err,
  input logic       ms_tick,
  input logic [1:0] mode,
  input logic       unlock_n
);
  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> unlock_n);

  p_pass_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (unlock_n == !(up_err || dn_err)));

  p_fall_needs_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(unlock_n) && mode[1] && $past(mode[1])) |-> $past(up_err || dn_err));

  p_release_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(unlock_n) && mode[1] && $past(mode[1])) |-> $past(ms_tick));

  p_no_release_mid_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && $past(mode[1]) && !$past(unlock_n) && $past(up_err || dn_err)
     && (up_err || dn_err)) |-> !unlock_n);
endmodule

bind pll_unlock_watch ulw_checker u_ulw_chk (
  .clk(clk), .rst_n(rst_n), .up_err(up_err), .dn_err(dn_err),
  .ms_tick(ms_tick), .mode(mode), .unlock_n(unlock_n)
);

// File: tb/pll_unlock_watch_bench.sv
module pll_unlock_watch_bench;
  localparam int TN = 4;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n, up_err, dn_err, ms_tick;
  logic [1:0] mode;
  logic unlock_n;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pll_unlock_watch #(.THR_NARROW(TN), .THR_WIDE(TW), .EXT_TICKS(2)) u_pll_unlock_watch (
    .clk(clk), .rst_n(rst_n), .up_err(up_err), .dn_err(dn_err),
    .ms_tick(ms_tick), .mode(mode), .unlock_n(unlock_n)
  );

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (unlock_n !== exp) begin
      n_bad++;
      $display("FAIL %s: unlock_n=%b expected=%b", tag, unlock_n, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive error high for w sampled cycles, then low; returns at negedge after last high edge
  task automatic pulse(input int w, input bit use_dn);
    if (use_dn) dn_err = 1'b1; else up_err = 1'b1;
    cyc(w);
    up_err = 1'b0;
    dn_err = 1'b0;
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    cyc(1);
    ms_tick = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; up_err = 1'b0; dn_err = 1'b0; ms_tick = 1'b0; mode = 2'b10;
    cyc(3);
    check(1'b1, "R1 reset level");
    rst_n = 1'b1;
    cyc(4);
    check(1'b1, "R1 after reset release");

    // R4/R5/R6 sweep: widths, both limits, both inputs
    for (int m = 2; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int w = 1; w <= 12; w++) begin
          int lim;
          lim = (m == 3) ? TW : TN;
          mode = 2'(m);
          cyc(1);
          pulse(w, d[0]);
          check((w > lim) ? 1'b0 : 1'b1, (m == 3) ? "R5 R6 wide width sweep" : "R4 R6 narrow width sweep");
          tick(); tick();
          cyc(1);
          check(1'b1, "R7 cleared after two ticks");
        end
      end
    end

    // R7 tick-by-tick
    mode = 2'b10;
    pulse(TN + 1, 1'b0);
    cyc(3);
    check(1'b0, "R7 low before any tick");
    tick();
    cyc(5);
    check(1'b0, "R7 low after first tick");
    tick();
    check(1'b1, "R7 high after second tick");

    // R7: ticks during a long pulse do not release
    up_err = 1'b1;
    cyc(TN + 2);
    tick(); tick(); tick();
    check(1'b0, "R7 held while error persists");
    up_err = 1'b0;
    tick();
    check(1'b0, "R7 still low one tick after pulse");
    tick();
    check(1'b1, "R7 released two ticks after pulse");

    // R8 restart
    pulse(TN + 2, 1'b1);
    tick();
    pulse(TN + 2, 1'b0);
    tick();
    check(1'b0, "R8 restart keeps low after next tick");
    tick();
    check(1'b1, "R8 released after two ticks from restart");

    // R9 leaving comparing mode
    pulse(TN + 3, 1'b0);
    check(1'b0, "R9 flagged before mode change");
    mode = 2'b00;
    cyc(1);
    check(1'b1, "R2 stop forces high");
    mode = 2'b10;
    cyc(1);
    check(1'b1, "R9 stretch cleared by mode exit");

    // R2 stopped mode with long error
    mode = 2'b00;
    up_err = 1'b1;
    cyc(20);
    check(1'b1, "R2 stopped ignores long up error");
    up_err = 1'b0; dn_err = 1'b1;
    cyc(3);
    check(1'b1, "R2 stopped ignores down error");
    dn_err = 1'b0;

    // R3 pass-through, same cycle
    mode = 2'b01;
    #1 check(1'b1, "R3 pass idle");
    up_err = 1'b1;
    #1 check(1'b0, "R3 pass up");
    up_err = 1'b0; dn_err = 1'b1;
    #1 check(1'b0, "R3 pass down");
    dn_err = 1'b0;
    #1 check(1'b1, "R3 pass released");
    cyc(1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule